// File: doc/BRIEF.md
# Image Sensor Frame Timing Generator

This block paces the readout of a two-lane pixel array. Each pixel clock moves two pixels, so a row of N output columns needs only ceil(N/2) clocks of active data. A column counter runs in pixel clocks across the row, and a row counter steps once per row across the frame. The line length (clocks per row, active plus horizontal blanking) and the frame length (rows per frame, active plus vertical blanking) come from programmed values. Each is raised to a computed floor when the programmed value is too small.

The line floor is the largest of three limits. One is fixed by the conversion speed of the ADC. One is set by the digital readout of the output columns. One is set by the output interface. The frame floor is the number of output rows plus a vertical blanking made of optical-black rows, two embedded-data rows and two blank rows. Every row is tagged with its type, and line-valid and frame-valid flags mark the active pixel region.

All settings pass through shadow registers. These load while reset is held and on the last clock of each frame, so a frame always runs on one consistent set of values.

Top module: `sensor_frame_timer`

## Requirements
- R1: While `rstN` is low (synchronous, active low), `colCnt` and `rowCnt` are 0 and every configuration input is copied into the shadow registers. The first frame after reset therefore runs on the values present during reset.
- R2: `colCnt` counts 0 to L-1 and then wraps to 0, where L is the effective line length. On each wrap `rowCnt` steps by one, and it returns to 0 after row F-1, where F is the effective frame length.
- R3: The ADC line limit is 1204 clocks when `adcFast` is 0 and 1116 clocks when `adcFast` is 1.
- R4: The output column count is C = (xEnd - xStart + 1) >> s. Here s is 2 when the increment field is 7 or more, 1 when it is 3 to 6, and 0 otherwise. The digital limit is floor(C/3) and the interface limit is floor(C/2) + 96. The line floor is the largest of these two limits and the ADC limit.
- R5: The effective line length is `lineLenProg` when that is at least the line floor, and the line floor otherwise.
- R6: With output row count Rn = (yEnd - yStart + 1) >> s, using the same decode of `yInc`, the frame floor is Rn + B + 4, where B is the optical-black row count. The effective frame length is `frameLenProg` when that is at least the floor, and the floor otherwise.
- R7: The optical-black row count B is 4 for code 4'h4, 2 for code 4'h2, and 8 for every other code, including the default 4'h8.
- R8: Rows of a frame run in this order: Rn active rows, then B optical-black rows, then 2 embedded rows, then blank rows to the end of the frame. `rowType` encodes active as 0, optical-black as 1, embedded as 2 and blank as 3.
- R9: When `embedEn` is 0, the two embedded rows are reported as blank (`rowType` 3).
- R10: `frameValid` is high for every clock of the active rows. `lineValid` is high only in active rows, while `colCnt` < ceil(C/2).
- R11: Configuration inputs are sampled only in the last clock of a frame. A change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| xStart | input | COORD_W | First column of the readout window |
| xEnd | input | COORD_W | Last column of the readout window |
| xInc | input | 3 | Column increment field (1, 3, 7) |
| yStart | input | COORD_W | First row of the readout window |
| yEnd | input | COORD_W | Last row of the readout window |
| yInc | input | 3 | Row increment field (1, 3, 7) |
| adcFast | input | 1 | High-speed ADC mode select |
| obCode | input | 4 | Optical-black row count code |
| embedEn | input | 1 | Embedded rows carry data when 1 |
| lineLenProg | input | LEN_W | Programmed clocks per row |
| frameLenProg | input | LEN_W | Programmed rows per frame |
| colCnt | output | LEN_W | Column position in pixel clocks |
| rowCnt | output | LEN_W | Row position within the frame |
| lineValid | output | 1 | Active pixel data on this clock |
| frameValid | output | 1 | Current row lies in the active region |
| rowType | output | 2 | Row class: 0 active, 1 OB, 2 embedded, 3 blank |

## Verification
The configuration reload and the frame wrap happen in the same clock. When the counters return to row 0 column 0, the shadow registers take the new inputs, and the limits, floors and row boundaries of the new frame all change at that edge. The bench provokes this on every frame: it drives the next setting on the first clock of a frame. It then expects the row length, the frame length, the line-valid pattern and the row-type sequence of that frame to follow the old setting. The frame after it must follow the new setting exactly from its first clock.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic [1:0] {
    ROW_ACTIVE = 2'd0,
    ROW_OB     = 2'd1,
    ROW_EMBED  = 2'd2,
    ROW_BLANK  = 2'd3
  } row_kind_t;

  typedef struct packed {
    logic rowEnd;
    logic loadCfg;
  } ftg_strobe_t;

endpackage

// File: rtl/ftg_window.sv
module ftg_window #(
  parameter int COORD_W = 12,
  parameter int OUT_W   = 16
) (
  input  logic [COORD_W-1:0] first,
  input  logic [COORD_W-1:0] last,
  input  logic [2:0]         inc,
  output logic [OUT_W-1:0]   count
);
  localparam int SPAN_W = COORD_W + 1;

  logic [SPAN_W-1:0] span;
  logic [1:0]        shiftAmt;

  always_comb begin
    span = {1'b0, last} - {1'b0, first} + SPAN_W'(1);
    if (inc >= 3'd7)      shiftAmt = 2'd2;
    else if (inc >= 3'd3) shiftAmt = 2'd1;
    else                  shiftAmt = 2'd0;
    count = OUT_W'(span >> shiftAmt);
  end
endmodule

// File: rtl/ftg_datapath.sv
module ftg_datapath
  import ftg_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int LEN_W      = 16,
  parameter int ADC_NORMAL = 1204,
  parameter int ADC_FAST   = 1116,
  parameter int OUT_PAD    = 96,
  parameter int EMBED_ROWS = 2,
  parameter int BLANK_ROWS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] xStart,
  input  logic [COORD_W-1:0] xEnd,
  input  logic [2:0]         xInc,
  input  logic [COORD_W-1:0] yStart,
  input  logic [COORD_W-1:0] yEnd,
  input  logic [2:0]         yInc,
  input  logic               adcFast,
  input  logic [3:0]         obCode,
  input  logic               embedEn,
  input  logic [LEN_W-1:0]   lineLenProg,
  input  logic [LEN_W-1:0]   frameLenProg,
  input  ftg_strobe_t        strobe,
  output logic [LEN_W-1:0]   lineLen,
  output logic [LEN_W-1:0]   frameLen,
  output logic [LEN_W-1:0]   activeCols,
  output logic [LEN_W-1:0]   activeRows,
  output logic [LEN_W-1:0]   obRows,
  output logic               embedOn
);
  localparam int VBLANK_FIXED = EMBED_ROWS + BLANK_ROWS;

  // shadow copies, refreshed in reset and at the frame wrap only
  logic [COORD_W-1:0] sXStart, sXEnd, sYStart, sYEnd;
  logic [2:0]         sXInc, sYInc;
  logic               sAdcFast, sEmbed;
  logic [3:0]         sObCode;
  logic [LEN_W-1:0]   sLineProg, sFrameProg;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadCfg) begin
      sXStart    <= xStart;
      sXEnd      <= xEnd;
      sXInc      <= xInc;
      sYStart    <= yStart;
      sYEnd      <= yEnd;
      sYInc      <= yInc;
      sAdcFast   <= adcFast;
      sObCode    <= obCode;
      sEmbed     <= embedEn;
      sLineProg  <= lineLenProg;
      sFrameProg <= frameLenProg;
    end
  end

  logic [LEN_W-1:0] outCols, outRows;

  ftg_window #(.COORD_W(COORD_W), .OUT_W(LEN_W)) uColWin (
    .first(sXStart), .last(sXEnd), .inc(sXInc), .count(outCols)
  );
  ftg_window #(.COORD_W(COORD_W), .OUT_W(LEN_W)) uRowWin (
    .first(sYStart), .last(sYEnd), .inc(sYInc), .count(outRows)
  );

  logic [LEN_W-1:0] adcLim, digLim, ifLim, lineFloor, frameFloor;

  always_comb begin
    adcLim = sAdcFast ? LEN_W'(ADC_FAST) : LEN_W'(ADC_NORMAL);
    digLim = outCols / LEN_W'(3);
    ifLim  = (outCols >> 1) + LEN_W'(OUT_PAD);
    lineFloor = adcLim;
    if (digLim > lineFloor) lineFloor = digLim;
    if (ifLim > lineFloor)  lineFloor = ifLim;
    lineLen = (sLineProg >= lineFloor) ? sLineProg : lineFloor;

    case (sObCode)
      4'h4:    obRows = LEN_W'(4);
      4'h2:    obRows = LEN_W'(2);
      default: obRows = LEN_W'(8);
    endcase
    frameFloor = outRows + obRows + LEN_W'(VBLANK_FIXED);
    frameLen   = (sFrameProg >= frameFloor) ? sFrameProg : frameFloor;

    activeCols = (outCols + LEN_W'(1)) >> 1;
    activeRows = outRows;
    embedOn    = sEmbed;
  end

  // R11: shadow state holds between reload strobes
  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> ($stable(sXEnd) && $stable(sYEnd) && $stable(sObCode)
                         && $stable(sLineProg) && $stable(sFrameProg) && $stable(sAdcFast)));
  // R2: a frame reload only comes with a row end
  a_r2_reload_on_row_end: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |-> strobe.rowEnd);
  // R3: line length never falls below the fast ADC figure
  a_r3_line_floor: assert property (@(posedge clk) disable iff (!rstN)
    lineLen >= LEN_W'(ADC_FAST));
  // R6: frame always holds active rows plus the whole vertical blanking
  a_r6_frame_floor: assert property (@(posedge clk) disable iff (!rstN)
    frameLen >= activeRows + obRows + LEN_W'(VBLANK_FIXED));
endmodule

// File: rtl/ftg_control.sv
module ftg_control
  import ftg_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int EMBED_ROWS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] lineLen,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [LEN_W-1:0] activeCols,
  input  logic [LEN_W-1:0] activeRows,
  input  logic [LEN_W-1:0] obRows,
  input  logic             embedOn,
  output ftg_strobe_t      strobe,
  output logic [LEN_W-1:0] colCnt,
  output logic [LEN_W-1:0] rowCnt,
  output logic             lineValid,
  output logic             frameValid,
  output logic [1:0]       rowType
);
  logic lastCol, lastRow;
  logic [LEN_W-1:0] obEnd, embEnd;
  row_kind_t kind;

  always_comb begin
    lastCol = (colCnt == lineLen - LEN_W'(1));
    lastRow = (rowCnt == frameLen - LEN_W'(1));
    strobe.rowEnd  = lastCol;
    strobe.loadCfg = lastCol && lastRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (lastCol) begin
      colCnt <= '0;
      rowCnt <= lastRow ? '0 : rowCnt + LEN_W'(1);
    end else begin
      colCnt <= colCnt + LEN_W'(1);
    end
  end

  always_comb begin
    obEnd  = activeRows + obRows;
    embEnd = obEnd + LEN_W'(EMBED_ROWS);
    if (rowCnt < activeRows)  kind = ROW_ACTIVE;
    else if (rowCnt < obEnd)  kind = ROW_OB;
    else if (rowCnt < embEnd) kind = embedOn ? ROW_EMBED : ROW_BLANK;
    else                      kind = ROW_BLANK;
    rowType    = kind;
    frameValid = (kind == ROW_ACTIVE);
    lineValid  = frameValid && (colCnt < activeCols);
  end

  // R2: column position stays inside the row
  a_r2_col_in_row: assert property (@(posedge clk) disable iff (!rstN)
    colCnt < lineLen);
  // R2: a row end that is not the frame end advances the row by one
  a_r2_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (lastCol && !lastRow) |=> (rowCnt == $past(rowCnt) + LEN_W'(1)));
  // R10: pixel data only inside the active region
  a_r10_line_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (frameValid && rowType == 2'd0));
  // R9: embedded code only appears while embedding is on
  a_r9_embed_gate: assert property (@(posedge clk) disable iff (!rstN)
    (rowType == 2'd2) |-> embedOn);
endmodule

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer
  import ftg_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int LEN_W      = 16,
  parameter int ADC_NORMAL = 1204,
  parameter int ADC_FAST   = 1116,
  parameter int OUT_PAD    = 96,
  parameter int EMBED_ROWS = 2,
  parameter int BLANK_ROWS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] xStart,
  input  logic [COORD_W-1:0] xEnd,
  input  logic [2:0]         xInc,
  input  logic [COORD_W-1:0] yStart,
  input  logic [COORD_W-1:0] yEnd,
  input  logic [2:0]         yInc,
  input  logic               adcFast,
  input  logic [3:0]         obCode,
  input  logic               embedEn,
  input  logic [LEN_W-1:0]   lineLenProg,
  input  logic [LEN_W-1:0]   frameLenProg,
  output logic [LEN_W-1:0]   colCnt,
  output logic [LEN_W-1:0]   rowCnt,
  output logic               lineValid,
  output logic               frameValid,
  output logic [1:0]         rowType
);
  ftg_strobe_t      strobe;
  logic [LEN_W-1:0] lineLen, frameLen, activeCols, activeRows, obRows;
  logic             embedOn;

  ftg_datapath #(
    .COORD_W(COORD_W), .LEN_W(LEN_W), .ADC_NORMAL(ADC_NORMAL), .ADC_FAST(ADC_FAST),
    .OUT_PAD(OUT_PAD), .EMBED_ROWS(EMBED_ROWS), .BLANK_ROWS(BLANK_ROWS)
  ) uData (
    .clk(clk), .rstN(rstN),
    .xStart(xStart), .xEnd(xEnd), .xInc(xInc),
    .yStart(yStart), .yEnd(yEnd), .yInc(yInc),
    .adcFast(adcFast), .obCode(obCode), .embedEn(embedEn),
    .lineLenProg(lineLenProg), .frameLenProg(frameLenProg),
    .strobe(strobe),
    .lineLen(lineLen), .frameLen(frameLen), .activeCols(activeCols),
    .activeRows(activeRows), .obRows(obRows), .embedOn(embedOn)
  );

  ftg_control #(.LEN_W(LEN_W), .EMBED_ROWS(EMBED_ROWS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lineLen(lineLen), .frameLen(frameLen), .activeCols(activeCols),
    .activeRows(activeRows), .obRows(obRows), .embedOn(embedOn),
    .strobe(strobe),
    .colCnt(colCnt), .rowCnt(rowCnt),
    .lineValid(lineValid), .frameValid(frameValid), .rowType(rowType)
  );
endmodule

// File: tb/tb_sensor_frame_timer.sv
`timescale 1ns/1ps
module tb_sensor_frame_timer;
  localparam int NV = 5;

  typedef struct packed {
    logic [11:0] xs; logic [11:0] xe; logic [2:0] xi;
    logic [11:0] ys; logic [11:0] ye; logic [2:0] yi;
    logic fast; logic [3:0] ob; logic emb;
    logic [15:0] lp; logic [15:0] fp;
    logic [15:0] eLine; logic [15:0] eFrame; logic [15:0] eCols;
    logic [15:0] eRows; logic [15:0] eOb;
  } vec_t;

  // xs xe xi ys ye yi fast ob emb lp fp | line frame cols rows ob
  localparam vec_t VEC [NV] = '{
    '{12'd0,   12'd1279, 3'd1, 12'd0,  12'd3,  3'd1, 1'b0, 4'h2, 1'b1, 16'd0,    16'd0,
      16'd1204, 16'd10, 16'd640,  16'd4, 16'd2},
    '{12'd0,   12'd1279, 3'd1, 12'd0,  12'd7,  3'd3, 1'b1, 4'h4, 1'b0, 16'd1150, 16'd5,
      16'd1150, 16'd12, 16'd640,  16'd4, 16'd4},
    '{12'd100, 12'd3099, 3'd1, 12'd0,  12'd15, 3'd7, 1'b0, 4'h2, 1'b1, 16'd0,    16'd11,
      16'd1596, 16'd11, 16'd1500, 16'd4, 16'd2},
    '{12'd0,   12'd3999, 3'd3, 12'd10, 12'd12, 3'd1, 1'b1, 4'h8, 1'b1, 16'd0,    16'd0,
      16'd1116, 16'd15, 16'd1000, 16'd3, 16'd8},
    '{12'd0,   12'd4000, 3'd1, 12'd0,  12'd1,  3'd1, 1'b0, 4'hF, 1'b1, 16'd0,    16'd0,
      16'd2096, 16'd14, 16'd2001, 16'd2, 16'd8}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [11:0] xStart, xEnd, yStart, yEnd;
  logic [2:0]  xInc, yInc;
  logic        adcFast, embedEn;
  logic [3:0]  obCode;
  logic [15:0] lineLenProg, frameLenProg;
  logic [15:0] colCnt, rowCnt;
  logic        lineValid, frameValid;
  logic [1:0]  rowType;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sensor_frame_timer dut (
    .clk(clk), .rstN(rstN),
    .xStart(xStart), .xEnd(xEnd), .xInc(xInc),
    .yStart(yStart), .yEnd(yEnd), .yInc(yInc),
    .adcFast(adcFast), .obCode(obCode), .embedEn(embedEn),
    .lineLenProg(lineLenProg), .frameLenProg(frameLenProg),
    .colCnt(colCnt), .rowCnt(rowCnt),
    .lineValid(lineValid), .frameValid(frameValid), .rowType(rowType)
  );

  task automatic drive(input int k);
    xStart = VEC[k].xs; xEnd = VEC[k].xe; xInc = VEC[k].xi;
    yStart = VEC[k].ys; yEnd = VEC[k].ye; yInc = VEC[k].yi;
    adcFast = VEC[k].fast; obCode = VEC[k].ob; embedEn = VEC[k].emb;
    lineLenProg = VEC[k].lp; frameLenProg = VEC[k].fp;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(0);
    repeat (3) @(negedge clk);
    check("R1", "colCnt in reset", int'(colCnt), 0);
    check("R1", "rowCnt in reset", int'(rowCnt), 0);
    rstN = 1'b1;

    // vector walk: each frame starts at this negedge with counters at 0,
    // the next setting is driven mid-frame and must only apply afterwards
    for (int k = 0; k < NV; k++) begin
      int row0Len, maxRow, lvRow0, lvErr, typeErr, cyc;
      row0Len = 0; maxRow = 0; lvRow0 = 0; lvErr = 0; typeErr = 0; cyc = 0;
      if (k + 1 < NV) drive(k + 1);
      do begin
        int r, expType;
        bit expLv;
        r = int'(rowCnt);
        if (colCnt == 16'd0) begin
          if (r < VEC[k].eRows) expType = 0;
          else if (r < VEC[k].eRows + VEC[k].eOb) expType = 1;
          else if (r < VEC[k].eRows + VEC[k].eOb + 2) expType = VEC[k].emb ? 2 : 3;
          else expType = 3;
          if (int'(rowType) != expType) typeErr++;
          if (frameValid != (expType == 0)) typeErr++;
        end
        expLv = (r < VEC[k].eRows) && (int'(colCnt) < VEC[k].eCols);
        if (lineValid != expLv) lvErr++;
        if (r == 0) begin
          row0Len++;
          if (lineValid) lvRow0++;
        end
        if (r > maxRow) maxRow = r;
        @(negedge clk);
        cyc++;
      end while (!(colCnt == 16'd0 && rowCnt == 16'd0));

      check("R3 R4 R5", $sformatf("vec%0d line length", k), row0Len, int'(VEC[k].eLine));
      check("R6 R7", $sformatf("vec%0d frame length", k), maxRow + 1, int'(VEC[k].eFrame));
      check("R10", $sformatf("vec%0d active clocks in row 0", k), lvRow0, int'(VEC[k].eCols));
      check("R10", $sformatf("vec%0d lineValid mismatches", k), lvErr, 0);
      check(VEC[k].emb ? "R8" : "R9", $sformatf("vec%0d row type mismatches", k), typeErr, 0);
      check("R2 R11", $sformatf("vec%0d frame clocks", k), cyc,
            int'(VEC[k].eLine) * int'(VEC[k].eFrame));
    end

    // reset mid-frame, with a new setting presented only during reset
    repeat (300) @(negedge clk);
    check("R2", "counters running before reset", int'(colCnt != 16'd0), 1);
    rstN = 1'b0;
    drive(0);
    repeat (2) @(negedge clk);
    check("R1", "colCnt after mid-frame reset", int'(colCnt), 0);
    check("R1", "rowCnt after mid-frame reset", int'(rowCnt), 0);
    check("R1", "rowType after mid-frame reset", int'(rowType), 0);
    rstN = 1'b1;
    begin
      int len;
      len = 0;
      do begin
        len++;
        @(negedge clk);
      end while (colCnt != 16'd0);
      check("R1", "line length loaded during reset", len, 1204);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule